// File: doc/BRIEF.md
# Write-Only Serial Gain Control Slave

This block is the control front end of a mono speaker amplifier. It watches a two-wire serial bus (clock and data) and oversamples both lines on a fast system clock. It answers one fixed 7-bit address and accepts only write transactions. Each accepted write carries exactly one control byte, which goes straight into the single control register. There is no register pointer and no read path.

The stored byte is split into a 5-bit volume step and two channel enables. From these the block drives a shutdown flag and a registered signed gain value in dB. A dedicated asynchronous active-low reset pin clears the register and blocks the bus. The data line is open-drain: the block only ever pulls it low, and it does so only while it acknowledges.

Top module: `amp_gain_ctrl`

## Requirements
- R1: While `hard_rst_n` is low, the outputs read `vol_code`=0, `en_a`=0, `en_b`=0, `shutdown`=1 and `gain_db`=-70, and no bus activity is acknowledged or stored.
- R2: A START is a falling data line while the clock is high. After a START, the first eight bits are sampled on clock rising edges, MSB first: the 7-bit address 1110110 followed by the direction bit. If the address matches and the direction bit is 0, the slave acknowledges.
- R3: If the address differs, or the direction bit is 1, the slave does not acknowledge, and nothing in the rest of that transaction is acknowledged or stored.
- R4: The slave acknowledges the byte that follows an accepted address, and stores it only once that acknowledge has completed. Bits 7..3 of the byte are the volume code (bit 7 is the MSB), bit 1 is `en_a`, bit 0 is `en_b`, and bit 2 has no effect.
- R5: A STOP (data rising while the clock is high), or a START, that arrives before the control byte is complete leaves the register unchanged.
- R6: A repeated START at any point restarts address reception, so a complete write that follows it is stored.
- R7: The acknowledge begins at the clock falling edge that ends the eighth bit, and it is held through the whole ninth clock-high period. It is released at the next clock falling edge. The slave does not pull the data line low at any other time.
- R8: `gain_db` follows the stored code one system clock later, as a two's-complement value:
  - Codes 0..16 give -70, -56, -46, -38, -32, -28, -24, -21, -18, -15, -12, -10, -8, -6, -4, -2, 0.
  - Codes 17..25 give 2*(code-16).
  - Codes 26..31 give code-7.
- R9: `shutdown` is 1 exactly when both enables are 0. Entering shutdown keeps the stored volume code and gain.
- R10: Any byte after the control byte in the same transaction is neither acknowledged nor stored.
- R11: After `hard_rst_n` returns high, the block stays in shutdown at code 0 until a new write is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bus bit rate |
| hard_rst_n | input | 1 | Asynchronous active-low reset; clears the register and blocks the bus |
| scl_in | input | 1 | Bus clock line as seen at the pin |
| sda_in | input | 1 | Bus data line as seen at the pin |
| sda_pull | output | 1 | 1 pulls the open-drain data line low (acknowledge) |
| vol_code | output | 5 | Stored volume step |
| en_a | output | 1 | Stored channel A enable |
| en_b | output | 1 | Stored channel B enable |
| shutdown | output | 1 | 1 when both enables are 0 |
| gain_db | output | 8 | Signed gain in dB for the stored volume step |

## Verification
The bench builds the block with its default parameters: slave address 1110110 and a two-stage synchronizer. It runs one bus bit every 32 system clocks, well above the required oversampling ratio. That leaves room to sample the data line in the middle of the ninth clock-high period and again just after the release edge, so the acknowledge window can be checked on both sides. With the default address, a sweep over all 32 volume codes through real bus writes reaches every gain entry. The same address setting also reaches the aborted, repeated-START, read-request, wrong-address and reset-held cases.

// File: rtl/agc_pkg.sv
package agc_pkg;

  localparam int BYTE_W   = 8;
  localparam int VOL_W    = 5;
  localparam int GAIN_W   = 8;
  localparam int VOL_LSB  = 3;
  localparam int RSVD_BIT = 2;
  localparam int ENA_BIT  = 1;
  localparam int ENB_BIT  = 0;

  typedef enum logic [2:0] {
    RX_IDLE,
    RX_ADDR,
    RX_AACK,
    RX_DATA,
    RX_DACK,
    RX_SKIP
  } rx_state_e;

  typedef struct packed {
    logic [VOL_W-1:0] vol;
    logic             en_a;
    logic             en_b;
  } ctrl_t;

  // Volume step to signed dB
  function automatic logic signed [GAIN_W-1:0] vol_to_db(input logic [VOL_W-1:0] code);
    logic signed [GAIN_W-1:0] r;
    int v;
    v = int'(code);
    if (v > 25) begin
      r = GAIN_W'(v - 7);
    end else if (v > 16) begin
      r = GAIN_W'(2 * (v - 16));
    end else begin
      case (code)
        5'd0:    r = -8'sd70;
        5'd1:    r = -8'sd56;
        5'd2:    r = -8'sd46;
        5'd3:    r = -8'sd38;
        5'd4:    r = -8'sd32;
        5'd5:    r = -8'sd28;
        5'd6:    r = -8'sd24;
        5'd7:    r = -8'sd21;
        5'd8:    r = -8'sd18;
        5'd9:    r = -8'sd15;
        5'd10:   r = -8'sd12;
        5'd11:   r = -8'sd10;
        5'd12:   r = -8'sd8;
        5'd13:   r = -8'sd6;
        5'd14:   r = -8'sd4;
        5'd15:   r = -8'sd2;
        default: r = 8'sd0;
      endcase
    end
    return r;
  endfunction

endpackage

// File: rtl/agc_bus_sync.sv
module agc_bus_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_s, scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/agc_frame_rx.sv
module agc_frame_rx
  import agc_pkg::*;
#(
  parameter int          ADDR_W     = 7,
  parameter logic [ADDR_W-1:0] SLAVE_ADDR = 7'b1110110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  output logic              ack_drive,
  output logic              wr_stb,
  output logic [BYTE_W-1:0] wr_byte
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  rx_state_e         state;
  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-1:0] sh;
  logic              addr_ok;

  assign addr_ok = (sh == {SLAVE_ADDR, 1'b0});
  assign wr_byte = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= RX_IDLE;
      cnt       <= '0;
      sh        <= '0;
      ack_drive <= 1'b0;
      wr_stb    <= 1'b0;
    end else begin
      wr_stb <= 1'b0;
      if (start_evt) begin
        state     <= RX_ADDR;
        cnt       <= '0;
        ack_drive <= 1'b0;
      end else if (stop_evt) begin
        state     <= RX_IDLE;
        ack_drive <= 1'b0;
      end else begin
        case (state)
          RX_ADDR, RX_DATA: begin
            if (scl_rise && cnt != FULL) begin
              sh  <= {sh[BYTE_W-2:0], sda_s};
              cnt <= cnt + 1'b1;
            end else if (scl_fall && cnt == FULL) begin
              if (state == RX_DATA) begin
                ack_drive <= 1'b1;
                state     <= RX_DACK;
              end else if (addr_ok) begin
                ack_drive <= 1'b1;
                state     <= RX_AACK;
              end else begin
                state <= RX_SKIP;
              end
            end
          end
          RX_AACK: begin
            if (scl_fall) begin
              ack_drive <= 1'b0;
              cnt       <= '0;
              state     <= RX_DATA;
            end
          end
          RX_DACK: begin
            if (scl_fall) begin
              ack_drive <= 1'b0;
              wr_stb    <= 1'b1;
              state     <= RX_SKIP;
            end
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/agc_ctrl_reg.sv
module agc_ctrl_reg
  import agc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [BYTE_W-1:0]        wr_byte,
  output ctrl_t                    ctrl_q,
  output logic signed [GAIN_W-1:0] gain_q
);

  logic unused_rsvd;
  assign unused_rsvd = wr_byte[RSVD_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      gain_q <= vol_to_db('0);
    end else begin
      if (wr_stb) begin
        ctrl_q.vol  <= wr_byte[VOL_LSB +: VOL_W];
        ctrl_q.en_a <= wr_byte[ENA_BIT];
        ctrl_q.en_b <= wr_byte[ENB_BIT];
      end
      gain_q <= vol_to_db(ctrl_q.vol);
    end
  end

endmodule

// File: rtl/amp_gain_ctrl.sv
module amp_gain_ctrl
  import agc_pkg::*;
#(
  parameter logic [6:0] SLAVE_ADDR  = 7'b1110110,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                     clk,
  input  logic                     hard_rst_n,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_pull,
  output logic [VOL_W-1:0]         vol_code,
  output logic                     en_a,
  output logic                     en_b,
  output logic                     shutdown,
  output logic signed [GAIN_W-1:0] gain_db
);

  // Named internal events, observed by the bound checker
  logic              sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic              ack_drive, wr_stb;
  logic [BYTE_W-1:0] wr_byte;
  ctrl_t             ctrl_q;

  agc_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (hard_rst_n),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  agc_frame_rx #(.ADDR_W(7), .SLAVE_ADDR(SLAVE_ADDR)) u_rx (
    .clk       (clk),
    .rst_n     (hard_rst_n),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt),
    .ack_drive (ack_drive),
    .wr_stb    (wr_stb),
    .wr_byte   (wr_byte)
  );

  agc_ctrl_reg u_reg (
    .clk     (clk),
    .rst_n   (hard_rst_n),
    .wr_stb  (wr_stb),
    .wr_byte (wr_byte),
    .ctrl_q  (ctrl_q),
    .gain_q  (gain_db)
  );

  assign sda_pull = ack_drive;
  assign vol_code = ctrl_q.vol;
  assign en_a     = ctrl_q.en_a;
  assign en_b     = ctrl_q.en_b;
  assign shutdown = ~(ctrl_q.en_a | ctrl_q.en_b);

endmodule

// File: rtl/agc_checker.sv
module agc_checker (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_fall,
  input logic              stop_evt,
  input logic              ack_drive,
  input logic              wr_stb,
  input logic [4:0]        vol_code,
  input logic              en_a,
  input logic              en_b,
  input logic signed [7:0] gain_db
);

  assert_ack_rise_after_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_drive) |-> $past(scl_fall));

  assert_ack_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_drive && scl_fall) |=> !ack_drive);

  assert_stop_drops_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !ack_drive);

  assert_commit_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |-> $past(ack_drive));

  assert_hold_without_commit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable({vol_code, en_a, en_b}));

  assert_gain_floor_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vol_code) == 5'd0) |-> (gain_db == -8'sd70));

  assert_gain_unity_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vol_code) == 5'd16) |-> (gain_db == 8'sd0));

  assert_gain_top_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vol_code) == 5'd31) |-> (gain_db == 8'sd24));

endmodule

bind amp_gain_ctrl agc_checker u_chk (
  .clk       (clk),
  .rst_n     (hard_rst_n),
  .scl_fall  (scl_fall),
  .stop_evt  (stop_evt),
  .ack_drive (ack_drive),
  .wr_stb    (wr_stb),
  .vol_code  (vol_code),
  .en_a      (en_a),
  .en_b      (en_b),
  .gain_db   (gain_db)
);

// File: tb/sim_amp_gain_ctrl.sv
module sim_amp_gain_ctrl;

  localparam time CLK_T = 10ns;
  localparam int  Q     = 8;      // system clocks per quarter bus bit
  localparam logic [6:0] DEV = 7'b1110110;

  logic clk = 1'b0;
  logic hard_rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_pull, en_a, en_b, shutdown;
  logic [4:0] vol_code;
  logic signed [7:0] gain_db;
  logic sda_line;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_T/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_pull;

  amp_gain_ctrl u0 (
    .clk(clk), .hard_rst_n(hard_rst_n), .scl_in(scl_m), .sda_in(sda_line),
    .sda_pull(sda_pull), .vol_code(vol_code), .en_a(en_a), .en_b(en_b),
    .shutdown(shutdown), .gain_db(gain_db)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ref_db(input int c);
    int lo[16] = '{-70, -56, -46, -38, -32, -28, -24, -21,
                   -18, -15, -12, -10, -8, -6, -4, -2};
    if (c >= 26) return c - 7;
    if (c >= 16) return 2 * c - 32;
    return lo[c];
  endfunction

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq(); wq();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
  endtask

  // Full byte plus ninth clock; reports ack seen, pull during bit 8 high, pull after release
  task automatic send_byte(input logic [7:0] b, output bit acked,
                           output bit early, output bit late);
    early = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq();
      if (i == 0) early = sda_pull;
      wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq();
    acked = (sda_line == 1'b0);
    wq(); scl_m = 1'b0; wq();
    late = sda_pull;
  endtask

  task automatic write_txn(input logic [6:0] a, input bit rw, input logic [7:0] d,
                           output bit ack_a, output bit ack_d);
    bit e, l;
    bus_start();
    send_byte({a, rw}, ack_a, e, l);
    send_byte(d, ack_d, e, l);
    bus_stop();
  endtask

  task automatic chk_regs(input string req, input int v, input int ea, input int eb);
    chk(req, int'(vol_code), v);
    chk(req, int'(en_a), ea);
    chk(req, int'(en_b), eb);
    chk(req, int'(gain_db), ref_db(v));
  endtask

  task automatic t_reset();
    chk_regs("R1 reset", 0, 0, 0);
    chk("R1 reset shutdown", int'(shutdown), 1);
    chk("R1 reset no pull", int'(sda_pull), 0);
  endtask

  task automatic t_basic_write();
    bit aa, ad;
    write_txn(DEV, 1'b0, 8'b10110_0_11, aa, ad);
    chk("R2 address ack", int'(aa), 1);
    chk("R4 data ack", int'(ad), 1);
    chk_regs("R4 fields", 22, 1, 1);
    chk("R9 enabled", int'(shutdown), 0);
    // bit 2 set must not matter
    write_txn(DEV, 1'b0, 8'b01001_1_10, aa, ad);
    chk_regs("R4 bit2 ignored", 9, 1, 0);
    chk("R11 single enable runs", int'(shutdown), 0);
  endtask

  task automatic t_ack_window();
    bit aa, e, l;
    bus_start();
    send_byte({DEV, 1'b0}, aa, e, l);
    chk("R7 no pull in bit 8 high", int'(e), 0);
    chk("R7 ack during ninth high", int'(aa), 1);
    chk("R7 released after ninth fall", int'(l), 0);
    bus_stop();
  endtask

  task automatic t_gain_sweep();
    bit aa, ad;
    for (int c = 0; c < 32; c++) begin
      write_txn(DEV, 1'b0, {c[4:0], 3'b011}, aa, ad);
      chk($sformatf("R8 gain code %0d", c), int'(gain_db), ref_db(c));
    end
  endtask

  task automatic t_bad_address();
    bit aa, ad;
    write_txn(DEV, 1'b0, 8'b01100_0_01, aa, ad);
    write_txn(7'b1110101, 1'b0, 8'b11111_0_10, aa, ad);
    chk("R3 wrong addr nack", int'(aa), 0);
    chk("R3 wrong addr data nack", int'(ad), 0);
    chk_regs("R3 wrong addr unchanged", 12, 0, 1);
    write_txn(DEV, 1'b1, 8'b00011_0_10, aa, ad);
    chk("R3 read nack", int'(aa), 0);
    chk("R3 read data nack", int'(ad), 0);
    chk_regs("R3 read unchanged", 12, 0, 1);
  endtask

  task automatic t_shutdown_keeps();
    bit aa, ad;
    write_txn(DEV, 1'b0, 8'b10100_0_11, aa, ad);
    write_txn(DEV, 1'b0, 8'b10100_0_00, aa, ad);
    chk("R9 shutdown on", int'(shutdown), 1);
    chk_regs("R9 volume kept", 20, 0, 0);
  endtask

  task automatic t_abort();
    bit aa, e, l;
    bus_start();
    send_byte({DEV, 1'b0}, aa, e, l);
    send_bits(8'b11111_0_11, 5);
    bus_stop();
    chk_regs("R5 stop abort unchanged", 20, 0, 0);
  endtask

  task automatic t_restart();
    bit aa, ad, e, l;
    bus_start();
    send_byte({DEV, 1'b0}, aa, e, l);
    send_bits(8'b00000_0_11, 4);
    bus_start();                              // repeated START
    chk_regs("R5 start abort unchanged", 20, 0, 0);
    send_byte({DEV, 1'b0}, aa, e, l);
    send_byte(8'b11010_0_01, ad, e, l);
    bus_stop();
    chk("R6 restart addr ack", int'(aa), 1);
    chk_regs("R6 restart stored", 26, 0, 1);
  endtask

  task automatic t_extra_byte();
    bit aa, ad, ax, e, l;
    bus_start();
    send_byte({DEV, 1'b0}, aa, e, l);
    send_byte(8'b00111_0_10, ad, e, l);
    send_byte(8'b11111_0_11, ax, e, l);
    bus_stop();
    chk("R10 second byte nack", int'(ax), 0);
    chk_regs("R10 first byte kept", 7, 1, 0);
  endtask

  task automatic t_hw_reset();
    bit aa, ad;
    write_txn(DEV, 1'b0, 8'b11100_0_11, aa, ad);
    @(negedge clk); hard_rst_n = 1'b0;
    @(negedge clk);
    chk_regs("R1 pin clears", 0, 0, 0);
    write_txn(DEV, 1'b0, 8'b11100_0_11, aa, ad);
    chk("R1 bus blocked ack", int'(aa), 0);
    chk_regs("R1 bus blocked store", 0, 0, 0);
    hard_rst_n = 1'b1;
    repeat (4 * Q) @(negedge clk);
    chk("R11 still shutdown", int'(shutdown), 1);
    chk_regs("R11 still code 0", 0, 0, 0);
    write_txn(DEV, 1'b0, 8'b10000_0_10, aa, ad);
    chk_regs("R11 write after reset", 16, 1, 0);
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    t_reset();
    hard_rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_basic_write();
    t_ack_window();
    t_gain_sweep();
    t_bad_address();
    t_shutdown_keeps();
    t_abort();
    t_restart();
    t_extra_byte();
    t_hw_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule